// File: doc/BRIEF.md
# Programmable Pulse Rate Divider

This block takes a slow pulse train from a tape transport's control track and produces one short output pulse for every N input events. A downstream speed-error detector and a timer use that output. Software programs the ratio through a write-only 8-bit divisor register. The low seven bits of that register hold N-1, and the top bit has no effect. A control input chooses what counts as an input event: rising edges only, or every transition.

The input is brought into the system clock domain by a two-stage synchronizer. Each transition is detected there and becomes a single-cycle event strobe. A down counter consumes these strobes. When the counter is at zero, the next event emits a one-cycle output pulse and reloads the counter from the reload register.

A register write restarts the count, so software can realign the output phase simply by rewriting the ratio. When the trigger-select control is low, the count also restarts on a single-cycle strobe marking the transport's change from playback to record. A ratio field of zero makes every event produce a pulse, with the same latency as in divide mode. Reads of the register return a fixed filler value of 0xFF that carries no meaning.

Top module: `pulse_div_top`

## Requirements
- R1: After `rst_n` is low or `standby_i` is high, the divisor register holds 0x80. Its ratio field (bits 6:0) is therefore 0 and the divider runs in pass-through, and `div_pulse_o` is low.
- R2: With ratio field F = `wr_data_i[6:0]` written, E counted events after the write give floor(E/(F+1)) output pulses. The first pulse comes on event F+1. Bit 7 of the written value has no effect on the division.
- R3: With F = 0, every counted event gives exactly one output pulse.
- R4: With `both_edges_i` = 0, only rising edges of `pulse_in_i` count. With `both_edges_i` = 1, rising and falling edges both count.
- R5: A write loads the reload register and the down counter in the same cycle. Any partial count made before the write is discarded, and counting restarts from F.
- R6: When `trig_sel_i` = 0, a one-cycle `rec_switch_i` strobe reloads the down counter from the reload register. When `trig_sel_i` = 1, the strobe has no effect.
- R7: If a write or an effective `rec_switch_i` strobe falls in the same cycle as a counted event, the reload wins and no output pulse is produced for that event.
- R8: `div_pulse_o` is high for one clock. It is asserted on the third rising clock edge after a counted transition of `pulse_in_i`, in both pass-through and divide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous return of the registers to their reset state |
| wr_en_i | input | 1 | Divisor register write strobe |
| wr_data_i | input | 8 | Write data; bits 6:0 hold N-1, bit 7 is ignored |
| rd_data_o | output | 8 | Read value, a fixed filler with no meaning |
| pulse_in_i | input | 1 | Asynchronous control-track pulse input |
| both_edges_i | input | 1 | 1: count both edges, 0: rising edges only |
| trig_sel_i | input | 1 | 0: playback-to-record strobe restarts the count |
| rec_switch_i | input | 1 | One-cycle playback-to-record switch strobe |
| div_pulse_o | output | 1 | Divided output pulse, one clock wide |

## Verification
The hardest case to reach from the ports is a reload that falls in exactly the same clock as a counted event. This requires knowing the synchronizer depth. The bench changes `pulse_in_i` on a falling clock edge, waits two rising edges so that the event strobe is live, and only then raises `wr_en_i` or `rec_switch_i`. In pass-through mode, a pulse is then expected for every event except that one. The ratio sweep then covers every field value from 0 to 7 in both edge modes, and each time compares the pulse count against floor(E/N).

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned FIELD_W = 7;
  localparam logic [DATA_W-1:0] RST_VAL = 8'h80;
  localparam logic [DATA_W-1:0] RD_FILL = 8'hFF;

  typedef struct packed {
    logic [FIELD_W-1:0] cnt;
    logic               hit;
  } cnt_step_t;

  // One counted event: decrement, or wrap to the reload value and flag a hit.
  function automatic cnt_step_t count_step(input logic [FIELD_W-1:0] cur,
                                           input logic [FIELD_W-1:0] reload);
    cnt_step_t s;
    if (cur == '0) begin
      s.cnt = reload;
      s.hit = 1'b1;
    end else begin
      s.cnt = cur - 1'b1;
      s.hit = 1'b0;
    end
    return s;
  endfunction
endpackage

// File: rtl/pdiv_edge_det.sv
module pdiv_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic both_i,
  output logic evt_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_prev_q;
  logic                   level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= async_i;
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign level = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_prev_q <= 1'b0;
    else        level_prev_q <= level;
  end

  assign rise_o = level & ~level_prev_q;
  assign fall_o = ~level & level_prev_q;
  assign evt_o  = rise_o | (both_i & fall_o);

  // R4
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !both_i) |-> level);

  // R4
  evt_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (sync_q[LAST] != $past(sync_q[LAST])));
endmodule

// File: rtl/pdiv_div_reg.sv
module pdiv_div_reg
  import pdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [FIELD_W-1:0] reload_o
);
  logic [DATA_W-1:0]  div_q;
  logic [FIELD_W-1:0] reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= RST_VAL;
      reload_q <= RST_VAL[FIELD_W-1:0];
    end else if (standby_i) begin
      div_q    <= RST_VAL;
      reload_q <= RST_VAL[FIELD_W-1:0];
    end else if (wr_en_i) begin
      div_q    <= wr_data_i;
      reload_q <= wr_data_i[FIELD_W-1:0];
    end
  end

  assign reload_o = reload_q;

  // R5
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !standby_i) |=> (div_q == $past(wr_data_i)));

  // R2
  reload_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_q == div_q[FIELD_W-1:0]);

  // R1
  standby_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (div_q == RST_VAL));
endmodule

// File: rtl/pdiv_down_cnt.sv
module pdiv_down_cnt
  import pdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby_i,
  input  logic               evt_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] load_val_i,
  input  logic [FIELD_W-1:0] reload_i,
  output logic [FIELD_W-1:0] cnt_o,
  output logic               pulse_o
);
  logic [FIELD_W-1:0] cnt_q;
  logic               pulse_q;
  cnt_step_t          step;

  always_comb step = count_step(cnt_q, reload_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RST_VAL[FIELD_W-1:0];
      pulse_q <= 1'b0;
    end else if (standby_i) begin
      cnt_q   <= RST_VAL[FIELD_W-1:0];
      pulse_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      pulse_q <= 1'b0;
    end else if (evt_i) begin
      cnt_q   <= step.cnt;
      pulse_q <= step.hit;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;

  // R7
  load_blocks_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !pulse_o);

  // R8
  pulse_from_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(evt_i && !load_i && !standby_i));

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !standby_i) |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/pulse_div_top.sv
module pulse_div_top
  import pdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              pulse_in_i,
  input  logic              both_edges_i,
  input  logic              trig_sel_i,
  input  logic              rec_switch_i,
  output logic              div_pulse_o
);
  logic               evt;
  logic               rise;
  logic               fall;
  logic               resync;
  logic               load;
  logic [FIELD_W-1:0] load_val;
  logic [FIELD_W-1:0] reload;
  logic [FIELD_W-1:0] cnt;

  pdiv_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pulse_in_i),
    .both_i  (both_edges_i),
    .evt_o   (evt),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  pdiv_div_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .reload_o  (reload)
  );

  assign resync   = rec_switch_i & ~trig_sel_i;
  assign load     = wr_en_i | resync;
  assign load_val = wr_en_i ? wr_data_i[FIELD_W-1:0] : reload;

  pdiv_down_cnt u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_i  (standby_i),
    .evt_i      (evt),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .pulse_o    (div_pulse_o)
  );

  assign rd_data_o = RD_FILL;

  // R2
  cnt_le_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload);

  // R6
  resync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_switch_i && !wr_en_i && !trig_sel_i && !standby_i) |=> (cnt == reload));

  // R4
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

  // R3
  bypass_every_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !load && !standby_i && reload == '0 && cnt == '0) |=> div_pulse_o);
endmodule

// File: tb/pulse_div_top_bench.sv
`timescale 1ns/1ps
module pulse_div_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       pin = 1'b0;
  logic       both = 1'b0;
  logic       tsel = 1'b1;
  logic       rec = 1'b0;
  logic       dpulse;

  int checks = 0;
  int errors = 0;
  int pulse_total = 0;
  int wide_pulses = 0;
  logic prev_pulse = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  pulse_div_top u_pulse_div_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .pulse_in_i   (pin),
    .both_edges_i (both),
    .trig_sel_i   (tsel),
    .rec_switch_i (rec),
    .div_pulse_o  (dpulse)
  );

  always @(negedge clk) begin
    if (dpulse) pulse_total++;
    if (dpulse && prev_pulse) wide_pulses++;
    prev_pulse <= dpulse;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_div(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    cyc(2);
  endtask

  // One full input period: rise then fall, each held for 4 clocks.
  task automatic period();
    @(negedge clk); pin = 1'b1; cyc(4);
    pin = 1'b0; cyc(4);
  endtask

  initial begin
    int base;
    cyc(3);
    check("R1 reset pulse low", int'(dpulse), 0);
    rst_n = 1'b1;
    cyc(2);

    // R1/R3: after reset ratio field is 0, every rising edge pulses
    base = pulse_total;
    repeat (3) period();
    check("R1 bypass after reset", pulse_total - base, 3);

    // R8: latency and width in bypass mode
    @(negedge clk); pin = 1'b1;
    cyc(1); check("R8 lat1", int'(dpulse), 0);
    cyc(1); check("R8 lat2", int'(dpulse), 0);
    cyc(1); check("R8 lat3", int'(dpulse), 1);
    cyc(1); check("R8 width", int'(dpulse), 0);
    pin = 1'b0; cyc(4);

    // R8: latency in divide mode (N=2, second event pulses)
    write_div(8'h01);
    period();
    @(negedge clk); pin = 1'b1;
    cyc(2); check("R8 div lat2", int'(dpulse), 0);
    cyc(1); check("R8 div lat3", int'(dpulse), 1);
    cyc(1); check("R8 div width", int'(dpulse), 0);
    pin = 1'b0; cyc(4);

    // R2/R3/R4/R5: sweep field 0..7 in both edge modes; bit 7 toggled
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < 8; f++) begin
        int p;
        int e;
        both = m[0];
        p = 2 * (f + 1) + 1;
        e = p * (m + 1);
        period(); // leaves a partial count that the write must discard
        write_div({f[0], f[6:0]});
        base = pulse_total;
        repeat (p) period();
        cyc(4);
        if (f == 0) check("R3 bypass count", pulse_total - base, e);
        else if (m == 1) check("R4 both edges", pulse_total - base, e / (f + 1));
        else check("R2 divide count", pulse_total - base, e / (f + 1));
      end
    end
    both = 1'b0;

    // R5: rewrite mid-count restarts phase (N=4)
    write_div(8'h03);
    repeat (3) period();
    write_div(8'h03);
    base = pulse_total;
    repeat (3) period();
    check("R5 restart no pulse", pulse_total - base, 0);
    period();
    check("R5 restart pulse on 4th", pulse_total - base, 1);

    // R6: resync with trig_sel=0 (N=4, 2 events, resync, 3 events -> 0)
    tsel = 1'b0;
    write_div(8'h03);
    base = pulse_total;
    repeat (2) period();
    @(negedge clk); rec = 1'b1; @(negedge clk); rec = 1'b0;
    repeat (3) period();
    check("R6 resync active", pulse_total - base, 0);
    // trig_sel=1: strobe ignored
    tsel = 1'b1;
    write_div(8'h03);
    base = pulse_total;
    repeat (2) period();
    @(negedge clk); rec = 1'b1; @(negedge clk); rec = 1'b0;
    repeat (3) period();
    check("R6 resync ignored", pulse_total - base, 1);

    // R7: write coincides with counted event in bypass mode
    write_div(8'h00);
    base = pulse_total;
    @(negedge clk); pin = 1'b1;
    cyc(2); wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    cyc(4); pin = 1'b0; cyc(4);
    check("R7 write wins", pulse_total - base, 0);
    base = pulse_total;
    period();
    check("R7 next event pulses", pulse_total - base, 1);
    // R7: resync strobe coincides with event
    tsel = 1'b0;
    base = pulse_total;
    @(negedge clk); pin = 1'b1;
    cyc(2); rec = 1'b1;
    @(negedge clk); rec = 1'b0;
    cyc(4); pin = 1'b0; cyc(4);
    check("R7 resync wins", pulse_total - base, 0);
    tsel = 1'b1;

    // R1: standby returns to bypass
    write_div(8'h05);
    @(negedge clk); standby = 1'b1; @(negedge clk); standby = 1'b0;
    cyc(2);
    base = pulse_total;
    repeat (2) period();
    check("R1 standby bypass", pulse_total - base, 2);

    check("R8 single-clock pulses", wide_pulses, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule